// File: doc/BRIEF.md
# Boot Remap and Abort Decoder

This block decodes the processor address map during and after boot. After reset, the lowest 1 MB window of the address space (which includes the exception vectors at 0x00 to 0x20) is served by the external boot device on chip-select 0. A boot-mode pin sampled at reset selects whether that device is 8 bits or 16 bits wide. Software then writes a one-way control bit. The bit moves the low window over to internal SRAM and unlocks the other external chip selects. The bit stays set until the next reset.

The address space has three parts. Internal space lies below 0x0040_0000, and it contains a fixed SRAM alias at 0x0030_0000–0x003F_FFFF. External space runs from 0x0040_0000 up to 0xFFBF_FFFF. Peripheral space begins at 0xFFC0_0000. The external space holds one 1 MB bank per chip select, with bank i starting at 0x0040_0000 + i·0x0100_0000. Any other external address is undefined. An access to an undefined external address produces a one-cycle abort, and so does an access to a locked bank. Internal and peripheral accesses never abort.

Top module: `boot_remap_decoder`

## Requirements
- R1: `boot_is_16` is 1 when `boot_pin` was 0 at the last clock edge with `rst` high, and 0 when `boot_pin` was 1. Later changes of `boot_pin` have no effect on it until the next reset.
- R2: Before remap, a strobed access with address bits [31:20] equal to 0 asserts `sel_cs[0]` and leaves `sel_sram` low.
- R3: A cycle with `cfg_wr`=1 and `cfg_bit`=1 sets `remap_state` to 1 at the next edge. From then on, the low window asserts `sel_sram` and not `sel_cs[0]`.
- R4: `cfg_wr` with `cfg_bit`=0 never clears `remap_state`. Only `rst` returns it to 0, and reset also gives the low window back to `sel_cs[0]`.
- R5: Before remap, `sel_cs[7:1]` stay 0. A strobed access inside bank 1–7 raises `abort_pulse` instead.
- R6: After remap, an access at an offset below 1 MB in bank i asserts only `sel_cs[i]`. Bank 0 decodes at all times.
- R7: A strobed access to an external address outside every bank drives `abort_pulse` high on the cycle after the access, for exactly one cycle per access cycle.
- R8: Internal accesses, including undefined internal addresses, never raise `abort_pulse`. Accesses at or above 0xFFC0_0000 never raise it either, and they assert `sel_periph`.
- R9: While `bus_rd` and `bus_wr` are both 0, no select is asserted and no abort is raised.
- R10: Addresses 0x0030_0000–0x003F_FFFF assert `sel_sram` whether or not the remap has happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_pin | input | 1 | Boot width strap, sampled while in reset |
| bus_addr | input | 32 | Processor address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| cfg_wr | input | 1 | Write strobe for the remap control bit |
| cfg_bit | input | 1 | Data for the remap control bit |
| remap_state | output | 1 | Read-back of the remap bit |
| boot_is_16 | output | 1 | Boot device is 16 bits wide |
| sel_cs | output | 8 | External chip selects |
| sel_sram | output | 1 | Internal SRAM select |
| sel_periph | output | 1 | Peripheral space select |
| abort_pulse | output | 1 | Abort for an undefined or locked external access |

## Verification
The selects are combinational, so they are due in the same cycle as the strobed address. The bench samples them one time unit after it drives the inputs on the falling edge. `abort_pulse` is registered. The bench reads it just after the rising edge that ends the access cycle, and again one edge later to confirm that the pulse has dropped. `remap_state` changes at the edge that ends the `cfg_wr` cycle. `boot_is_16` takes the value from the last edge of reset, so the bench drives the strap during reset and changes it afterwards to show the output holds.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
    localparam int ADDR_W      = 32;
    localparam int NUM_CS      = 8;
    localparam int STRIDE_LOG2 = 24;
    localparam int BANK_LOG2   = 20;
    localparam int LOW_LOG2    = 20;
    localparam logic [31:0] EXT_BASE    = 32'h0040_0000;
    localparam logic [31:0] PERIPH_BASE = 32'hFFC0_0000;
    localparam logic [31:0] ALIAS_BASE  = 32'h0030_0000;

    typedef enum logic [1:0] {
        SPACE_INT    = 2'd0,
        SPACE_EXT    = 2'd1,
        SPACE_PERIPH = 2'd2
    } space_e;

    typedef enum logic {
        BOOT_W8  = 1'b0,
        BOOT_W16 = 1'b1
    } boot_w_e;

    typedef struct packed {
        space_e space;
        logic   low_hit;
        logic   alias_hit;
        logic   bank_ok;
    } addr_class_t;
endpackage

// File: rtl/bm_remap_ctrl.sv
module bm_remap_ctrl
    import bootmap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    boot_pin,
    input  logic    cfg_wr,
    input  logic    cfg_bit,
    output logic    remapped,
    output boot_w_e boot_w
);
    always_ff @(posedge clk) begin
        if (rst) begin
            remapped <= 1'b0;
            boot_w   <= boot_pin ? BOOT_W8 : BOOT_W16;
        end else if (cfg_wr && cfg_bit) begin
            remapped <= 1'b1;
        end
    end
endmodule

// File: rtl/bm_addr_decode.sv
module bm_addr_decode
    import bootmap_pkg::*;
#(
    parameter int              A_W     = 32,
    parameter int              N_CS    = 8,
    parameter int              STR_L2  = 24,
    parameter int              BNK_L2  = 20,
    parameter int              LOW_L2  = 20,
    parameter logic [A_W-1:0]  E_BASE  = 32'h0040_0000,
    parameter logic [A_W-1:0]  P_BASE  = 32'hFFC0_0000,
    parameter logic [A_W-1:0]  AL_BASE = 32'h0030_0000
) (
    input  logic [A_W-1:0]  addr,
    input  logic            access,
    input  logic            remapped,
    output logic [N_CS-1:0] sel_cs,
    output logic            sel_sram,
    output logic            sel_periph,
    output logic            undefined
);
    localparam int IDX_W = A_W - STR_L2;

    addr_class_t            cls;
    logic [A_W-1:0]         ext_off;
    logic [IDX_W-1:0]       bank_idx;
    logic                   bank_locked;

    always_comb begin
        ext_off  = addr - E_BASE;
        bank_idx = ext_off[A_W-1:STR_L2];
        if (addr < E_BASE)        cls.space = SPACE_INT;
        else if (addr >= P_BASE)  cls.space = SPACE_PERIPH;
        else                      cls.space = SPACE_EXT;
        cls.low_hit   = (addr[A_W-1:LOW_L2] == '0);
        cls.alias_hit = (addr >= AL_BASE) && (addr < E_BASE);
        cls.bank_ok   = (ext_off[STR_L2-1:BNK_L2] == '0) &&
                        (bank_idx < IDX_W'(N_CS));
        bank_locked   = !remapped && (bank_idx != '0);
    end

    for (genvar i = 0; i < N_CS; i++) begin : g_cs
        logic bank_hit;
        assign bank_hit = access && (cls.space == SPACE_EXT) && cls.bank_ok &&
                          (bank_idx == IDX_W'(i));
        if (i == 0) begin : g_boot
            assign sel_cs[i] = bank_hit ||
                               (access && cls.low_hit && !remapped);
        end else begin : g_gated
            assign sel_cs[i] = bank_hit && remapped;
        end
    end

    assign sel_sram   = access && (cls.alias_hit || (cls.low_hit && remapped));
    assign sel_periph = access && (cls.space == SPACE_PERIPH);
    assign undefined  = access && (cls.space == SPACE_EXT) &&
                        (!cls.bank_ok || bank_locked);
endmodule

// File: rtl/bm_abort_gen.sv
module bm_abort_gen (
    input  logic clk,
    input  logic rst,
    input  logic undefined,
    output logic abort_q
);
    always_ff @(posedge clk) begin
        if (rst) abort_q <= 1'b0;
        else     abort_q <= undefined;
    end
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
    import bootmap_pkg::*;
#(
    parameter int                 ADDR_W_P    = ADDR_W,
    parameter int                 NUM_CS_P    = NUM_CS,
    parameter int                 STRIDE_L2_P = STRIDE_LOG2,
    parameter int                 BANK_L2_P   = BANK_LOG2,
    parameter int                 LOW_L2_P    = LOW_LOG2,
    parameter logic [ADDR_W_P-1:0] EXT_BASE_P  = EXT_BASE,
    parameter logic [ADDR_W_P-1:0] PER_BASE_P  = PERIPH_BASE,
    parameter logic [ADDR_W_P-1:0] ALIAS_P     = ALIAS_BASE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                boot_pin,
    input  logic [ADDR_W_P-1:0] bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic                cfg_wr,
    input  logic                cfg_bit,
    output logic                remap_state,
    output logic                boot_is_16,
    output logic [NUM_CS_P-1:0] sel_cs,
    output logic                sel_sram,
    output logic                sel_periph,
    output logic                abort_pulse
);
    logic    access;
    logic    remapped;
    logic    undefined;
    boot_w_e boot_w;

    assign access = bus_rd || bus_wr;

    bm_remap_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .boot_pin (boot_pin),
        .cfg_wr   (cfg_wr),
        .cfg_bit  (cfg_bit),
        .remapped (remapped),
        .boot_w   (boot_w)
    );

    bm_addr_decode #(
        .A_W     (ADDR_W_P),
        .N_CS    (NUM_CS_P),
        .STR_L2  (STRIDE_L2_P),
        .BNK_L2  (BANK_L2_P),
        .LOW_L2  (LOW_L2_P),
        .E_BASE  (EXT_BASE_P),
        .P_BASE  (PER_BASE_P),
        .AL_BASE (ALIAS_P)
    ) u_dec (
        .addr       (bus_addr),
        .access     (access),
        .remapped   (remapped),
        .sel_cs     (sel_cs),
        .sel_sram   (sel_sram),
        .sel_periph (sel_periph),
        .undefined  (undefined)
    );

    bm_abort_gen u_abort (
        .clk       (clk),
        .rst       (rst),
        .undefined (undefined),
        .abort_q   (abort_pulse)
    );

    assign remap_state = remapped;
    assign boot_is_16  = (boot_w == BOOT_W16);
endmodule

// File: rtl/bm_chk.sv
module bm_chk #(
    parameter int                 AW  = 32,
    parameter int                 NCS = 8,
    parameter logic [AW-1:0]      EB  = 32'h0040_0000,
    parameter logic [AW-1:0]      PB  = 32'hFFC0_0000
) (
    input logic           clk,
    input logic           rst,
    input logic [AW-1:0]  bus_addr,
    input logic           bus_rd,
    input logic           bus_wr,
    input logic           cfg_wr,
    input logic           cfg_bit,
    input logic           remap_state,
    input logic           boot_is_16,
    input logic [NCS-1:0] sel_cs,
    input logic           sel_sram,
    input logic           sel_periph,
    input logic           abort_pulse
);
    // R1
    boot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(boot_is_16));
    // R3
    remap_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_bit) |=> remap_state);
    // R4
    remap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        remap_state |=> remap_state);
    // R5
    cs_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !remap_state |-> (sel_cs[NCS-1:1] == '0));
    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_cs, sel_sram, sel_periph}));
    // R7
    abort_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) && bus_addr >= EB && bus_addr < PB &&
        (sel_cs == '0) |=> abort_pulse);
    // R8
    no_abort_int_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) && (bus_addr < EB || bus_addr >= PB) |=> !abort_pulse);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |-> (sel_cs == '0 && !sel_sram && !sel_periph));
    // R9
    idle_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |=> !abort_pulse);
endmodule

bind boot_remap_decoder bm_chk #(
    .AW  (ADDR_W_P),
    .NCS (NUM_CS_P),
    .EB  (EXT_BASE_P),
    .PB  (PER_BASE_P)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .cfg_wr      (cfg_wr),
    .cfg_bit     (cfg_bit),
    .remap_state (remap_state),
    .boot_is_16  (boot_is_16),
    .sel_cs      (sel_cs),
    .sel_sram    (sel_sram),
    .sel_periph  (sel_periph),
    .abort_pulse (abort_pulse)
);

// File: tb/sim_boot_remap_decoder.sv
`timescale 1ns/1ps
module sim_boot_remap_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_pin = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_bit = 1'b0;
    logic        remap_state, boot_is_16, sel_sram, sel_periph, abort_pulse;
    logic [7:0]  sel_cs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    boot_remap_decoder u0 (
        .clk(clk), .rst(rst), .boot_pin(boot_pin), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .cfg_wr(cfg_wr), .cfg_bit(cfg_bit),
        .remap_state(remap_state), .boot_is_16(boot_is_16), .sel_cs(sel_cs),
        .sel_sram(sel_sram), .sel_periph(sel_periph), .abort_pulse(abort_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Strobed access: selects sampled in the access cycle, abort after its edge.
    task automatic probe(input logic [31:0] a, input bit wr,
                         output logic [9:0] sels, output logic ab);
        @(negedge clk);
        bus_addr = a; bus_rd = !wr; bus_wr = wr;
        #1;
        sels = {sel_sram, sel_periph, sel_cs};
        @(posedge clk); #1;
        ab = abort_pulse;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_reset(input bit pin);
        @(negedge clk);
        rst = 1'b1; boot_pin = pin;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input bit v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_bit = v;
        @(posedge clk); #1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_bit = 1'b0;
    endtask

    task automatic t_reset_and_boot();
        do_reset(1'b1);
        #1;
        chk("R1 pin=1 gives 8-bit", {31'd0, boot_is_16}, 32'd0);
        chk("R4 reset remap_state", {31'd0, remap_state}, 32'd0);
        chk("R9 reset abort", {31'd0, abort_pulse}, 32'd0);
        boot_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 pin change after reset ignored", {31'd0, boot_is_16}, 32'd0);
        do_reset(1'b0);
        #1;
        chk("R1 pin=0 gives 16-bit", {31'd0, boot_is_16}, 32'd1);
        boot_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 held after pin toggles", {31'd0, boot_is_16}, 32'd1);
    endtask

    task automatic t_pre_remap();
        logic [9:0] s; logic ab;
        probe(32'h0000_0000, 1'b0, s, ab);
        chk("R2 vector fetch selects cs0", {22'd0, s}, 32'h001);
        probe(32'h000F_FFFC, 1'b1, s, ab);
        chk("R2 top of low window cs0", {22'd0, s}, 32'h001);
        probe(32'h0040_0010, 1'b0, s, ab);
        chk("R6 bank0 decodes before remap", {22'd0, s}, 32'h001);
        chk("R6 bank0 no abort", {31'd0, ab}, 32'd0);
        probe(32'h0140_0000, 1'b0, s, ab);
        chk("R5 bank1 locked selects", {22'd0, s}, 32'h000);
        chk("R5 bank1 locked abort", {31'd0, ab}, 32'd1);
        probe(32'h0740_0100, 1'b1, s, ab);
        chk("R5 bank7 locked abort", {22'd0, s, ab}, 32'h1);
        probe(32'h0030_0040, 1'b0, s, ab);
        chk("R10 alias before remap", {22'd0, s}, 32'h200);
    endtask

    task automatic t_remap();
        logic [9:0] s; logic ab;
        cfg_write(1'b0);
        chk("R4 write 0 before remap no effect", {31'd0, remap_state}, 32'd0);
        cfg_write(1'b1);
        chk("R3 remap_state after write 1", {31'd0, remap_state}, 32'd1);
        probe(32'h0000_0004, 1'b0, s, ab);
        chk("R3 low window now SRAM", {22'd0, s}, 32'h200);
        cfg_write(1'b0);
        chk("R4 write 0 after remap ignored", {31'd0, remap_state}, 32'd1);
        probe(32'h0000_0008, 1'b0, s, ab);
        chk("R4 low window still SRAM", {22'd0, s}, 32'h200);
        for (int i = 0; i < 8; i++) begin
            probe(32'h0040_0000 + i * 32'h0100_0000 + 32'h0000_0400, 1'b0, s, ab);
            chk($sformatf("R6 bank %0d select", i), {22'd0, s}, 32'h1 << i);
            chk($sformatf("R6 bank %0d no abort", i), {31'd0, ab}, 32'd0);
        end
        probe(32'h0030_0000, 1'b1, s, ab);
        chk("R10 alias after remap", {22'd0, s}, 32'h200);
    endtask

    task automatic t_undefined();
        logic [9:0] s; logic ab;
        probe(32'h0050_0000, 1'b0, s, ab);
        chk("R7 gap in bank0 stride selects", {22'd0, s}, 32'h000);
        chk("R7 gap in bank0 stride abort", {31'd0, ab}, 32'd1);
        @(posedge clk); #1;
        chk("R7 abort lasts one cycle", {31'd0, abort_pulse}, 32'd0);
        probe(32'h0900_0000, 1'b1, s, ab);
        chk("R7 beyond last bank abort", {31'd0, ab}, 32'd1);
        probe(32'h0020_0000, 1'b0, s, ab);
        chk("R8 undefined internal no select", {22'd0, s}, 32'h000);
        chk("R8 undefined internal no abort", {31'd0, ab}, 32'd0);
        probe(32'hFFFF_F000, 1'b1, s, ab);
        chk("R8 peripheral select", {22'd0, s}, 32'h100);
        chk("R8 peripheral no abort", {31'd0, ab}, 32'd0);
        probe(32'hFFC0_0000, 1'b0, s, ab);
        chk("R8 peripheral base no abort", {22'd0, s, ab}, 32'h200);
    endtask

    task automatic t_idle();
        @(negedge clk);
        bus_addr = 32'h0050_0000; bus_rd = 1'b0; bus_wr = 1'b0;
        #1;
        chk("R9 idle no selects", {22'd0, sel_sram, sel_periph, sel_cs}, 32'h000);
        @(posedge clk); #1;
        chk("R9 idle no abort", {31'd0, abort_pulse}, 32'd0);
    endtask

    task automatic t_reset_clears();
        logic [9:0] s; logic ab;
        do_reset(1'b1);
        #1;
        chk("R4 reset clears remap", {31'd0, remap_state}, 32'd0);
        probe(32'h0000_0000, 1'b0, s, ab);
        chk("R4 low window back to cs0", {22'd0, s}, 32'h001);
        probe(32'h0240_0000, 1'b0, s, ab);
        chk("R5 bank2 locked again", {22'd0, s, ab}, 32'h1);
    endtask

    initial begin
        t_reset_and_boot();
        t_pre_remap();
        t_remap();
        t_undefined();
        t_idle();
        t_reset_clears();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule